// File: doc/BRIEF.md
# Nine-Bit FIFO with Graded Occupancy Flags

This block is a single-clock first-in first-out buffer for nine-bit words, with a depth of 2048 or 4096 words set by a parameter. Writes and reads are parallel and use one strobe each. Read data is registered, so a word appears on the output on the clock edge that takes the read strobe. The output then holds until the next accepted read.

Six active-low status flags describe how full the buffer is. They run from empty, through a near-empty flag and a combined near-either-end flag, to half full, one-short-of-full and full. Each flag is computed from the word count that results from the operation on a clock edge, and is registered on that same edge.

A mode input tells the block that the downstream consumer shifts words out serially. In that mode the near-empty flag asserts one word earlier, which gives the consumer time to fetch the next word while the current one is shifted out.

Top module: `occ_flag_fifo`

## Requirements
- R1: While `rst` is high on a rising edge, the count, both pointers and `rd_data` clear to zero. Afterwards `empty_n`, `emptyp1_n` and `almost_n` read 0, and `half_n`, `fullm1_n` and `full_n` read 1.
- R2: Words leave in the order they were accepted. A read accepted on edge k presents the oldest word on `rd_data` right after edge k, and `rd_data` then holds until the next accepted read.
- R3: Every flag is registered and reflects the count after the operation on the most recent edge. `empty_n` is 0 exactly when that count is 0.
- R4: With `ser_out_mode` = 0 during the cycle, `emptyp1_n` is 0 exactly when the resulting count is 0 or 1.
- R5: With `ser_out_mode` = 1 during the cycle, `emptyp1_n` is 0 exactly when the resulting count is 2 or less.
- R6: `almost_n` is 0 when the count is below DEPTH/8 or above DEPTH - DEPTH/8. At depth 2048 these ranges are 0..255 and 1793..2048.
- R7: `half_n` is 0 exactly when the count exceeds DEPTH/2.
- R8: `fullm1_n` is 0 exactly when the count is DEPTH-1 or DEPTH.
- R9: `full_n` is 0 exactly when the count equals DEPTH. A write strobe while full is ignored, and the stored words and their order are unchanged.
- R10: A read while full is always accepted, even with a write strobe on the same edge. `full_n` returns to 1 and the count drops by one.
- R11: A read strobe while empty is ignored. `rd_data` holds and every flag stays as it was. A write on the same edge is still accepted.
- R12: Simultaneous read and write strobes on a buffer that is neither empty nor full leave the count, and therefore every flag, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_out_mode | input | 1 | 1 = serial consumer; moves the near-empty threshold up by one word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH (9) | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH (9) | Registered word from the last accepted read |
| empty_n | output | 1 | 0 when no words are held |
| emptyp1_n | output | 1 | 0 at one word or fewer (two or fewer in serial mode) |
| almost_n | output | 1 | 0 within one eighth of depth of either end |
| half_n | output | 1 | 0 when more than half full |
| fullm1_n | output | 1 | 0 at one word short of full, or full |
| full_n | output | 1 | 0 when every word is occupied |

## Verification
A count that drifts by one shows up on the next edge as a flag change at the wrong occupancy. This is most visible at the tight thresholds around 0, 1, 2, DEPTH-1 and DEPTH, so the bench checks every flag after every operation while it sweeps the count from empty to full and back. A pointer that moves on an ignored strobe does not change the flags. It appears only when the affected word is read, as the wrong data or the wrong order, possibly thousands of cycles later. For that reason every read is compared with a reference queue, and the buffer is drained completely after the full and empty corner cases.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;

    typedef struct packed {
        logic empty_n;
        logic emptyp1_n;
        logic almost_n;
        logic half_n;
        logic fullm1_n;
        logic full_n;
    } occ_flags_t;

    localparam occ_flags_t FLAGS_AT_RESET = '{
        empty_n:   1'b0,
        emptyp1_n: 1'b0,
        almost_n:  1'b0,
        half_n:    1'b1,
        fullm1_n:  1'b1,
        full_n:    1'b1
    };

endpackage

// File: rtl/occ_fifo_ctrl.sv
module occ_fifo_ctrl #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count_next
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        // A full buffer refuses writes; an empty one refuses reads.
        wr_ok = wr_en && (st_q.count != FULL_CNT);
        rd_ok = rd_en && (st_q.count != '0);
        if (wr_ok) st_d.wptr = st_q.wptr + AW'(1);
        if (rd_ok) st_d.rptr = st_q.rptr + AW'(1);
        unique case ({wr_ok, rd_ok})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wptr       = st_q.wptr;
    assign rptr       = st_q.rptr;
    assign count_next = st_d.count;

endmodule

// File: rtl/occ_fifo_store.sv
module occ_fifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    typedef struct packed {
        logic [WIDTH-1:0] dout;
    } rd_t;

    rd_t st_d, st_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        st_d = st_q;
        if (re) st_d.dout = mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.dout;

endmodule

// File: rtl/occ_fifo_flags.sv
module occ_fifo_flags
    import occ_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count_next,
    input  logic          ser_mode,
    output occ_flags_t    flags
);
    localparam logic [CW-1:0] LO_MARK   = CW'(DEPTH / 8);
    localparam logic [CW-1:0] HI_MARK   = CW'(DEPTH - DEPTH / 8);
    localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);
    localparam logic [CW-1:0] NEAR_FULL = CW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] TWO       = CW'(2);

    occ_flags_t fl_d, fl_q;

    always_comb begin
        fl_d.empty_n   = (count_next != '0);
        fl_d.emptyp1_n = ser_mode ? (count_next > TWO) : (count_next > ONE);
        fl_d.almost_n  = !((count_next < LO_MARK) || (count_next > HI_MARK));
        fl_d.half_n    = !(count_next > HALF_MARK);
        fl_d.fullm1_n  = (count_next < NEAR_FULL);
        fl_d.full_n    = (count_next != FULL_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= FLAGS_AT_RESET;
        else     fl_q <= fl_d;
    end

    assign flags = fl_q;

endmodule

// File: rtl/occ_flag_fifo.sv
module occ_flag_fifo
    import occ_fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_out_mode,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             emptyp1_n,
    output logic             almost_n,
    output logic             half_n,
    output logic             fullm1_n,
    output logic             full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count_next;
    occ_flags_t    flags;

    occ_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .wptr       (wptr),
        .rptr       (rptr),
        .count_next (count_next)
    );

    occ_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .waddr (wptr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (rptr),
        .rdata (rd_data)
    );

    occ_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .count_next (count_next),
        .ser_mode   (ser_out_mode),
        .flags      (flags)
    );

    assign empty_n   = flags.empty_n;
    assign emptyp1_n = flags.emptyp1_n;
    assign almost_n  = flags.almost_n;
    assign half_n    = flags.half_n;
    assign fullm1_n  = flags.fullm1_n;
    assign full_n    = flags.full_n;

endmodule

// File: rtl/occ_fifo_chk.sv
module occ_fifo_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_out_mode,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty_n,
    input logic             emptyp1_n,
    input logic             almost_n,
    input logic             half_n,
    input logic             fullm1_n,
    input logic             full_n
);
    logic [5:0] flags;
    assign flags = {empty_n, emptyp1_n, almost_n, half_n, fullm1_n, full_n};

    // R1: first cycle out of reset shows the empty pattern
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == 6'b000111 && rd_data == '0));

    // R3: empty implies the lower graded flags are also asserted
    p_empty_nest_r3: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> (!emptyp1_n && !almost_n && half_n && fullm1_n && full_n));

    // R4: a released near-empty flag implies not empty
    p_emptyp1_nest_r4: assert property (@(posedge clk) disable iff (rst)
        emptyp1_n |-> empty_n);

    // R7: more than half full means at least several words held
    p_half_nest_r7: assert property (@(posedge clk) disable iff (rst)
        !half_n |-> (empty_n && emptyp1_n));

    // R8: full implies one-short-of-full, half and almost all asserted
    p_full_nest_r8: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (!fullm1_n && !half_n && !almost_n && empty_n));

    // R9: a lone write while full leaves it full
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en) |=> (!full_n && $stable(rd_data)));

    // R10: any read while full clears full
    p_full_release_r10: assert property (@(posedge clk) disable iff (rst)
        (!full_n && rd_en) |=> full_n);

    // R11: a lone read while empty changes nothing at the outputs
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en && ser_out_mode == $past(ser_out_mode))
        |=> ($stable(flags) && $stable(rd_data)));

    // R12: balanced read and write keeps every flag
    p_balanced_r12: assert property (@(posedge clk) disable iff (rst)
        (empty_n && full_n && wr_en && rd_en && ser_out_mode == $past(ser_out_mode))
        |=> $stable(flags));

endmodule

bind occ_flag_fifo occ_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_out_mode (ser_out_mode),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .empty_n      (empty_n),
    .emptyp1_n    (emptyp1_n),
    .almost_n     (almost_n),
    .half_n       (half_n),
    .fullm1_n     (fullm1_n),
    .full_n       (full_n)
);

// File: tb/sim_occ_flag_fifo.sv
module sim_occ_flag_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH = 9;
    localparam int DEPTH = 2048;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ser_out_mode = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic empty_n, emptyp1_n, almost_n, half_n, fullm1_n, full_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [WIDTH-1:0] model_q[$];
    logic [WIDTH-1:0] exp_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    occ_flag_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
        .clk, .rst, .ser_out_mode, .wr_en, .wr_data, .rd_en, .rd_data,
        .empty_n, .emptyp1_n, .almost_n, .half_n, .fullm1_n, .full_n
    );

    function automatic bit f_empty(int c);   return c != 0; endfunction
    function automatic bit f_emptyp1(int c, bit s); return s ? (c > 2) : (c > 1); endfunction
    function automatic bit f_almost(int c);  return !(c < DEPTH / 8 || c > DEPTH - DEPTH / 8); endfunction
    function automatic bit f_half(int c);    return !(c > DEPTH / 2); endfunction
    function automatic bit f_fullm1(int c);  return c < DEPTH - 1; endfunction
    function automatic bit f_full(int c);    return c != DEPTH; endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (count %0d)", req, what, act, exp, model_q.size());
        end
    endtask

    task automatic check_word(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s rd_data: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(bit s);
        int c = model_q.size();
        check_bit("R3", "empty_n", empty_n, f_empty(c));
        check_bit(s ? "R5" : "R4", "emptyp1_n", emptyp1_n, f_emptyp1(c, s));
        check_bit("R6", "almost_n", almost_n, f_almost(c));
        check_bit("R7", "half_n", half_n, f_half(c));
        check_bit("R8", "fullm1_n", fullm1_n, f_fullm1(c));
        check_bit("R9", "full_n", full_n, f_full(c));
    endtask

    // One clock of stimulus; inputs change at the falling edge, results sampled at the next one.
    task automatic do_op(bit w, bit r, bit s, string rtag);
        logic [WIDTH-1:0] d = WIDTH'($urandom);
        bit wok = w && (model_q.size() != DEPTH);
        bit rok = r && (model_q.size() != 0);
        wr_en = w; rd_en = r; ser_out_mode = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        if (rok) exp_data = model_q.pop_front();
        if (wok) model_q.push_back(d);
        check_flags(s);
        if (r) check_word(rtag, rd_data, exp_data);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset pattern
        check_bit("R1", "empty_n", empty_n, 1'b0);
        check_bit("R1", "emptyp1_n", emptyp1_n, 1'b0);
        check_bit("R1", "almost_n", almost_n, 1'b0);
        check_bit("R1", "half_n", half_n, 1'b1);
        check_bit("R1", "fullm1_n", fullm1_n, 1'b1);
        check_bit("R1", "full_n", full_n, 1'b1);
        check_word("R1", rd_data, '0);

        // R11: read on empty is ignored, data held
        do_op(1'b0, 1'b1, 1'b0, "R11");
        do_op(1'b0, 1'b1, 1'b1, "R11");

        // Low-count walk in both modes: R4, R5 thresholds at 0,1,2,3
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 4; i++) do_op(1'b1, 1'b0, bit'(m), "R2");
            for (int i = 0; i < 4; i++) do_op(1'b0, 1'b1, bit'(m), "R2");
        end

        // R11: write accepted together with a read on empty
        do_op(1'b1, 1'b1, 1'b0, "R11");
        do_op(1'b0, 1'b1, 1'b0, "R2");

        // Random mixed traffic, write-biased then read-biased
        for (int i = 0; i < 3000; i++) begin
            bit wb = (i < 1500) ? ($urandom_range(99) < 65) : ($urandom_range(99) < 35);
            do_op(wb, $urandom_range(99) < 50, bit'($urandom_range(1)), "R2");
        end

        // R12: balanced traffic in the middle
        while (model_q.size() < 600) do_op(1'b1, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 40; i++) do_op(1'b1, 1'b1, 1'b0, "R12");

        // Fill to full, crossing R6, R7, R8 and R9 thresholds
        while (model_q.size() < DEPTH) do_op(1'b1, 1'b0, bit'($urandom_range(1)), "R2");

        // R9: writes while full ignored
        for (int i = 0; i < 5; i++) do_op(1'b1, 1'b0, 1'b0, "R9");
        // R10: read with write while full: only the read is taken
        do_op(1'b1, 1'b1, 1'b0, "R10");
        do_op(1'b1, 1'b0, 1'b0, "R2");
        do_op(1'b0, 1'b1, 1'b0, "R10");

        // Drain completely; order proves the ignored writes stored nothing
        while (model_q.size() > 0) do_op(1'b0, 1'b1, bit'($urandom_range(1)), "R9");
        do_op(1'b0, 1'b1, 1'b0, "R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule